// File: doc/BRIEF.md
# Command Response Packet Builder

This block turns one decoded host command into the reply packet that a system-management controller sends back over its byte-serial host link. The host side hands over a packet type byte, a command byte, up to four argument bytes and the length of the packet counted from the command byte onward. For peripheral-bus packets it also hands over the bus result: a count of response bytes and an error magnitude. The builder composes the reply, including the status code and the echoed command, and streams it out one byte per handshake on a valid/ready port. The last byte is flagged.

A seconds counter inside the block serves the time read and time write commands. A prescaler advances it once every `TICKS_PER_SEC` clock cycles. The power-off and restart commands do not act on anything here. After their reply has gone out in full, each one raises a one-cycle request pulse. While a reply is draining, the command side is held off.

Top module: `cmd_reply_builder`

## Requirements
- R1: After reset, `out_valid`, `pwr_req` and `rst_req` are 0 and `cmd_ready` is 1.
- R2: A management packet (type 0x01) carrying command 0x12, 0x14, 0x19 or 0x21 gets the three-byte reply 0x01, 0x00, command.
- R3: Management command 0x22 always gets the four-byte error reply 0x02, 0x05, 0x01, command.
- R4: Management command 0x25 gets the three-byte reply 0x01, 0x00, 0x25 when `cmd_len` is exactly 4. For any other length it gets 0x02, 0x02, 0x01, 0x25.
- R5: Management command 0x03 gets seven bytes: 0x01, 0x00, 0x03, then the seconds counter value, most significant byte first. The value is the one held just before the edge that accepts the command.
- R6: Management command 0x09 gets the three-byte reply. On the accepting edge it loads the seconds counter with argument bytes 0..3 taken big-endian (argument 0 is the most significant byte, at `cmd_args[7:0]`) and clears the prescaler. The counter then adds 1 every `TICKS_PER_SEC` cycles and wraps from 0xFFFFFFFF to 0.
- R7: Management command 0x0A (power-off) and 0x11 (restart) get the three-byte reply. In the cycle after the last byte's handshake, `pwr_req` (0x0A) or `rst_req` (0x11) is high for exactly one cycle. The two pulses never occur together, and no other command produces either pulse.
- R8: A peripheral-bus packet (type 0x00) with `bus_cnt` N in 1..`BUS_MAX` gets 0x00, 0x00, then N data bytes. Data byte i is taken from `bus_data[8*i +: 8]`.
- R9: A peripheral-bus packet with `bus_cnt` 0 is a failed request and gets 0x00, `bus_err`, command byte.
- R10: An unknown command, or any packet type other than 0x00 and 0x01, is consumed without a reply: `out_valid` stays 0 and `cmd_ready` is 1 again in the next cycle.
- R11: `out_last` is 1 only on the final byte. `out_data` and `out_last` hold steady while `out_valid` is high and `out_ready` is low. `cmd_ready` stays low from the cycle after a replying command is accepted until the cycle after its last byte is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Builder can accept a command |
| cmd_type | input | 8 | Packet type byte |
| cmd_op | input | 8 | Command byte |
| cmd_args | input | ARG_MAX*8 | Argument bytes, byte i at [8*i +: 8] |
| cmd_len | input | CLEN_W | Byte count from the command byte onward |
| bus_cnt | input | BC_W | Peripheral-bus response byte count, 0 means failure |
| bus_err | input | 8 | Peripheral-bus error magnitude |
| bus_data | input | BUS_MAX*8 | Peripheral-bus response bytes |
| out_valid | output | 1 | Reply byte present |
| out_data | output | 8 | Reply byte |
| out_last | output | 1 | Final byte of the reply |
| out_ready | input | 1 | Consumer takes the byte |
| pwr_req | output | 1 | One-cycle power-off request |
| rst_req | output | 1 | One-cycle restart request |

## Verification
Timing is counted from the edge that accepts a command:
- The first reply byte is valid one cycle after that edge.
- Each later byte follows the handshake edge of the byte before it.
- The request pulse and the return of `cmd_ready` both fall in the cycle after the last handshake.

The bench drives its inputs and samples the outputs on falling edges, so every check lands in the cycle where the result is due. It records the index of the accepting edge for each time write and time read. The expected counter value is then the written value plus the number of whole prescaler periods between those two edges. A sweep covers all 256 management command codes, alternating free-flowing and stalled consumers. Further runs cover the argument-length and bus-count cases, unknown packet types, and counter wrap.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam logic [7:0] PT_BUS  = 8'h00;
  localparam logic [7:0] PT_MGMT = 8'h01;
  localparam logic [7:0] PT_ERR  = 8'h02;

  localparam logic [7:0] OP_TIME_RD  = 8'h03;
  localparam logic [7:0] OP_TIME_WR  = 8'h09;
  localparam logic [7:0] OP_PWR_OFF  = 8'h0A;
  localparam logic [7:0] OP_RESTART  = 8'h11;
  localparam logic [7:0] OP_ADDR_Q   = 8'h12;
  localparam logic [7:0] OP_AUTO     = 8'h14;
  localparam logic [7:0] OP_DEV_LIST = 8'h19;
  localparam logic [7:0] OP_PWR_MSG  = 8'h21;
  localparam logic [7:0] OP_IIC_CMB  = 8'h22;
  localparam logic [7:0] OP_IIC_GS   = 8'h25;

  localparam logic [7:0] ST_IIC_CMB = 8'h05;
  localparam logic [7:0] ST_IIC_LEN = 8'h02;

  typedef enum logic [1:0] {ACT_NONE, ACT_PWR, ACT_RST} act_e;
endpackage

// File: rtl/crb_clock.sv
module crb_clock #(
  parameter int TICKS_PER_SEC = 100_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] load_val,
  output logic [31:0] seconds
);
  localparam int PRE_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICKS_PER_SEC - 1);

  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre     <= '0;
      seconds <= '0;
    end else if (load) begin
      pre     <= '0;
      seconds <= load_val;
    end else if (pre == PRE_TOP) begin
      pre     <= '0;
      seconds <= seconds + 32'd1;
    end else begin
      pre <= pre + PRE_W'(1);
    end
  end

  assert_load_value_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> (seconds == $past(load_val)));

  assert_hold_between_ticks_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && pre != PRE_TOP) |=> $stable(seconds));
endmodule

// File: rtl/crb_compose.sv
module crb_compose
  import crb_pkg::*;
#(
  parameter int ARG_MAX   = 4,
  parameter int BUS_MAX   = 4,
  parameter int CLEN_W    = 4,
  parameter int BC_W      = 3,
  parameter int FRAME_MAX = 7,
  parameter int FL_W      = 3
) (
  input  logic [7:0]             pkt_type,
  input  logic [7:0]             op,
  input  logic [ARG_MAX*8-1:0]   args,
  input  logic [CLEN_W-1:0]      cmd_len,
  input  logic [BC_W-1:0]        bus_cnt,
  input  logic [7:0]             bus_err,
  input  logic [BUS_MAX*8-1:0]   bus_data,
  input  logic [31:0]            now_sec,
  output logic [FRAME_MAX*8-1:0] frame,
  output logic [FL_W-1:0]        frame_len,
  output act_e                   act,
  output logic                   time_wr,
  output logic [31:0]            time_val
);
  logic [7:0]      fb [FRAME_MAX];
  logic [BC_W-1:0] cnt_c;

  always_comb begin
    for (int i = 0; i < FRAME_MAX; i++) fb[i] = 8'h00;
    frame_len = '0;
    act       = ACT_NONE;
    time_wr   = 1'b0;
    time_val  = {args[7:0], args[15:8], args[23:16], args[31:24]};
    cnt_c     = (bus_cnt > BC_W'(BUS_MAX)) ? BC_W'(BUS_MAX) : bus_cnt;

    if (pkt_type == PT_BUS) begin
      fb[0] = PT_BUS;
      if (bus_cnt == '0) begin
        fb[1]     = bus_err;
        fb[2]     = op;
        frame_len = FL_W'(3);
      end else begin
        for (int i = 0; i < BUS_MAX; i++)
          if (BC_W'(i) < cnt_c) fb[2+i] = bus_data[8*i +: 8];
        frame_len = FL_W'(2) + FL_W'(cnt_c);
      end
    end else if (pkt_type == PT_MGMT) begin
      fb[0] = PT_MGMT;
      fb[2] = op;
      unique case (op)
        OP_ADDR_Q, OP_AUTO, OP_DEV_LIST, OP_PWR_MSG: frame_len = FL_W'(3);
        OP_PWR_OFF: begin frame_len = FL_W'(3); act = ACT_PWR; end
        OP_RESTART: begin frame_len = FL_W'(3); act = ACT_RST; end
        OP_TIME_WR: begin frame_len = FL_W'(3); time_wr = 1'b1; end
        OP_TIME_RD: begin
          fb[3] = now_sec[31:24];
          fb[4] = now_sec[23:16];
          fb[5] = now_sec[15:8];
          fb[6] = now_sec[7:0];
          frame_len = FL_W'(7);
        end
        OP_IIC_CMB: begin
          fb[0] = PT_ERR; fb[1] = ST_IIC_CMB; fb[2] = PT_MGMT; fb[3] = op;
          frame_len = FL_W'(4);
        end
        OP_IIC_GS: begin
          if (cmd_len == CLEN_W'(4)) begin
            frame_len = FL_W'(3);
          end else begin
            fb[0] = PT_ERR; fb[1] = ST_IIC_LEN; fb[2] = PT_MGMT; fb[3] = op;
            frame_len = FL_W'(4);
          end
        end
        default: frame_len = '0;
      endcase
    end

    for (int i = 0; i < FRAME_MAX; i++) frame[8*i +: 8] = fb[i];
  end
endmodule

// File: rtl/crb_serial.sv
module crb_serial
  import crb_pkg::*;
#(
  parameter int FRAME_MAX = 7,
  parameter int FL_W      = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [FRAME_MAX*8-1:0] frame,
  input  logic [FL_W-1:0]        frame_len,
  input  act_e                   act,
  output logic                   out_valid,
  output logic [7:0]             out_data,
  output logic                   out_last,
  input  logic                   out_ready,
  output logic                   pwr_req,
  output logic                   rst_req
);
  logic [7:0]      sb [FRAME_MAX];
  logic [FL_W-1:0] rem;
  act_e            act_q;

  assign out_valid = (rem != '0);
  assign out_last  = (rem == FL_W'(1));
  assign out_data  = sb[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rem     <= '0;
      act_q   <= ACT_NONE;
      pwr_req <= 1'b0;
      rst_req <= 1'b0;
      for (int i = 0; i < FRAME_MAX; i++) sb[i] <= 8'h00;
    end else begin
      pwr_req <= 1'b0;
      rst_req <= 1'b0;
      if (load && frame_len != '0) begin
        for (int i = 0; i < FRAME_MAX; i++) sb[i] <= frame[8*i +: 8];
        rem   <= frame_len;
        act_q <= act;
      end else if (out_valid && out_ready) begin
        for (int i = 0; i < FRAME_MAX - 1; i++) sb[i] <= sb[i+1];
        sb[FRAME_MAX-1] <= 8'h00;
        rem <= rem - FL_W'(1);
        if (out_last) begin
          pwr_req <= (act_q == ACT_PWR);
          rst_req <= (act_q == ACT_RST);
          act_q   <= ACT_NONE;
        end
      end
    end
  end

  assert_stall_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_idle_after_last_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> !out_valid);

  assert_no_load_while_busy_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !load);
endmodule

// File: rtl/cmd_reply_builder.sv
module cmd_reply_builder
  import crb_pkg::*;
#(
  parameter  int TICKS_PER_SEC = 100_000_000,
  parameter  int ARG_MAX       = 4,
  parameter  int BUS_MAX       = 4,
  parameter  int CLEN_W        = 4,
  localparam int BC_W          = $clog2(BUS_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [7:0]           cmd_type,
  input  logic [7:0]           cmd_op,
  input  logic [ARG_MAX*8-1:0] cmd_args,
  input  logic [CLEN_W-1:0]    cmd_len,
  input  logic [BC_W-1:0]      bus_cnt,
  input  logic [7:0]           bus_err,
  input  logic [BUS_MAX*8-1:0] bus_data,
  output logic                 out_valid,
  output logic [7:0]           out_data,
  output logic                 out_last,
  input  logic                 out_ready,
  output logic                 pwr_req,
  output logic                 rst_req
);
  localparam int FRAME_MAX = (BUS_MAX + 2 > 7) ? BUS_MAX + 2 : 7;
  localparam int FL_W      = $clog2(FRAME_MAX + 1);

  logic                   accept;
  logic [31:0]            now_sec;
  logic [FRAME_MAX*8-1:0] frame;
  logic [FL_W-1:0]        frame_len;
  act_e                   act;
  logic                   time_wr;
  logic [31:0]            time_val;

  assign cmd_ready = !out_valid;
  assign accept    = cmd_valid && cmd_ready;

  crb_clock #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_clock (
    .clk(clk), .rst(rst), .load(accept && time_wr), .load_val(time_val),
    .seconds(now_sec)
  );

  crb_compose #(
    .ARG_MAX(ARG_MAX), .BUS_MAX(BUS_MAX), .CLEN_W(CLEN_W), .BC_W(BC_W),
    .FRAME_MAX(FRAME_MAX), .FL_W(FL_W)
  ) u_compose (
    .pkt_type(cmd_type), .op(cmd_op), .args(cmd_args), .cmd_len(cmd_len),
    .bus_cnt(bus_cnt), .bus_err(bus_err), .bus_data(bus_data),
    .now_sec(now_sec), .frame(frame), .frame_len(frame_len), .act(act),
    .time_wr(time_wr), .time_val(time_val)
  );

  crb_serial #(.FRAME_MAX(FRAME_MAX), .FL_W(FL_W)) u_serial (
    .clk(clk), .rst(rst), .load(accept), .frame(frame), .frame_len(frame_len),
    .act(act), .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready), .pwr_req(pwr_req), .rst_req(rst_req)
  );

  assert_pulse_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pwr_req, rst_req}));

  assert_pulse_after_last_R7: assert property (@(posedge clk) disable iff (rst)
    (pwr_req || rst_req) |-> $past(out_valid && out_ready && out_last));

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
    (pwr_req || rst_req) |=> !(pwr_req || rst_req));
endmodule

// File: tb/cmd_reply_builder_bench.sv
module cmd_reply_builder_bench;
  localparam int T = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_type = 8'h0, cmd_op = 8'h0;
  logic [31:0] cmd_args = 32'h0;
  logic [3:0]  cmd_len = 4'd1;
  logic [2:0]  bus_cnt = 3'd0;
  logic [7:0]  bus_err = 8'h0;
  logic [31:0] bus_data = 32'h0;
  logic        out_valid, out_last, pwr_req, rst_req;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  logic [7:0]  exp_b [8];
  int          exp_n;
  logic [1:0]  exp_p;
  logic [31:0] t_val = 32'h0;
  int          t_acc = 0;
  int          acc;
  string       tag;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmd_reply_builder #(.TICKS_PER_SEC(T)) u_cmd_reply_builder (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_type(cmd_type), .cmd_op(cmd_op), .cmd_args(cmd_args), .cmd_len(cmd_len),
    .bus_cnt(bus_cnt), .bus_err(bus_err), .bus_data(bus_data),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready), .pwr_req(pwr_req), .rst_req(rst_req)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic set3(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    exp_b[0] = b0; exp_b[1] = b1; exp_b[2] = b2; exp_n = 3;
  endtask

  task automatic set_err(input logic [7:0] code, input logic [7:0] op);
    exp_b[0] = 8'h02; exp_b[1] = code; exp_b[2] = 8'h01; exp_b[3] = op; exp_n = 4;
  endtask

  // Bench model of the reply, from the requirements.
  task automatic model(input logic [7:0] ty, input logic [7:0] op, input int ln,
                       input int bc, input logic [7:0] be, input logic [31:0] bd);
    logic [31:0] tv;
    exp_n = 0; exp_p = 2'b00; tag = "R10";
    if (ty == 8'h00) begin
      if (bc == 0) begin set3(8'h00, be, op); tag = "R9"; end
      else begin
        exp_b[0] = 8'h00; exp_b[1] = 8'h00;
        for (int i = 0; i < bc; i++) exp_b[2+i] = bd[8*i +: 8];
        exp_n = 2 + bc; tag = "R8";
      end
    end else if (ty == 8'h01) begin
      case (op)
        8'h12, 8'h14, 8'h19, 8'h21: begin set3(8'h01, 8'h00, op); tag = "R2"; end
        8'h0A: begin set3(8'h01, 8'h00, op); exp_p = 2'b10; tag = "R7"; end
        8'h11: begin set3(8'h01, 8'h00, op); exp_p = 2'b01; tag = "R7"; end
        8'h09: begin set3(8'h01, 8'h00, op); tag = "R6"; end
        8'h22: begin set_err(8'h05, op); tag = "R3"; end
        8'h25: begin
          if (ln == 4) set3(8'h01, 8'h00, op); else set_err(8'h02, op);
          tag = "R4";
        end
        8'h03: begin
          tv = t_val + 32'((acc - t_acc - 1) / T);
          set3(8'h01, 8'h00, op);
          exp_b[3] = tv[31:24]; exp_b[4] = tv[23:16]; exp_b[5] = tv[15:8]; exp_b[6] = tv[7:0];
          exp_n = 7; tag = "R5";
        end
        default: ;
      endcase
    end
  endtask

  task automatic run(input logic [7:0] ty, input logic [7:0] op, input int ln,
                     input logic [31:0] args, input int bc, input logic [7:0] be,
                     input logic [31:0] bd, input bit stall);
    logic [7:0] got [8];
    int got_n, last_at;
    bit phase;
    logic [7:0] held;
    @(negedge clk);
    cmd_type = ty; cmd_op = op; cmd_len = 4'(ln); cmd_args = args;
    bus_cnt = 3'(bc); bus_err = be; bus_data = bd; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    acc = cyc + 1;            // index of the accepting edge
    model(ty, op, ln, bc, be, bd);
    if (ty == 8'h01 && op == 8'h09) begin t_val = {args[7:0], args[15:8], args[23:16], args[31:24]}; t_acc = acc; end
    @(negedge clk);
    cmd_valid = 1'b0;
    got_n = 0; last_at = -1; phase = 0; held = 8'h0;
    if (exp_n == 0) begin
      chk(cmd_ready == 1'b1, "R10 ready after unknown", 32'(cmd_ready), 1);
      for (int k = 0; k < 3; k++) begin
        chk(out_valid == 1'b0, "R10 no reply", 32'(out_valid), 0);
        @(negedge clk);
      end
      return;
    end
    chk(out_valid == 1'b1, {tag, " first byte due"}, 32'(out_valid), 1);
    for (int k = 0; k < 40; k++) begin
      if (out_valid) begin
        if (stall && !phase) begin
          out_ready = 1'b0; held = out_data; phase = 1;
        end else begin
          if (stall) chk(out_data == held, "R11 stable under stall", 32'(out_data), 32'(held));
          out_ready = 1'b1; phase = 0;
          if (got_n < 8) got[got_n] = out_data;
          if (out_last && last_at < 0) last_at = got_n;
          got_n++;
          if (out_last) begin
            chk(cmd_ready == 1'b0, "R11 ready low during reply", 32'(cmd_ready), 0);
            @(negedge clk);
            out_ready = 1'b0;
            break;
          end
        end
      end else out_ready = 1'b0;
      @(negedge clk);
    end
    chk(got_n == exp_n, {tag, " length"}, 32'(got_n), 32'(exp_n));
    chk(last_at == exp_n - 1, "R11 last flag position", 32'(last_at), 32'(exp_n - 1));
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk(got[i] == exp_b[i], {tag, " byte"}, 32'(got[i]), 32'(exp_b[i]));
    chk({pwr_req, rst_req} == exp_p, "R7 request pulse", 32'({pwr_req, rst_req}), 32'(exp_p));
    chk(cmd_ready == 1'b1, "R11 ready back", 32'(cmd_ready), 1);
    @(negedge clk);
    chk({pwr_req, rst_req} == 2'b00, "R7 pulse one cycle", 32'({pwr_req, rst_req}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 0);
    chk(cmd_ready == 1'b1, "R1 cmd_ready", 32'(cmd_ready), 1);
    chk({pwr_req, rst_req} == 2'b00, "R1 pulses", 32'({pwr_req, rst_req}), 0);

    // R6: write time first so the bench model holds a known value
    run(8'h01, 8'h09, 5, 32'h78563412, 0, 8'h0, 32'h0, 0);
    run(8'h01, 8'h03, 1, 32'h0, 0, 8'h0, 32'h0, 0);       // R5

    // Sweep all management codes, alternate stalled consumer
    for (int op = 0; op < 256; op++)
      run(8'h01, 8'(op), 1, 32'h0, 0, 8'h0, 32'h0, op[0]);

    // R4 length cases
    for (int ln = 0; ln < 8; ln++)
      run(8'h01, 8'h25, ln, 32'h0, 0, 8'h0, 32'h0, 0);

    // R6 counting and wrap
    run(8'h01, 8'h09, 5, 32'hFDFFFFFF, 0, 8'h0, 32'h0, 0);
    repeat (5 * T + 3) @(negedge clk);
    run(8'h01, 8'h03, 1, 32'h0, 0, 8'h0, 32'h0, 1);
    repeat (37) @(negedge clk);
    run(8'h01, 8'h03, 1, 32'h0, 0, 8'h0, 32'h0, 0);

    // R8 / R9 bus replies
    for (int bc = 0; bc <= 4; bc++)
      run(8'h00, 8'h2C, 3, 32'h0, bc, 8'h11 + 8'(bc), 32'hA1B2C3D4, bc[0]);
    run(8'h00, 8'h4F, 2, 32'h0, 0, 8'hFE, 32'h0, 1);

    // R10 unknown packet types
    for (int ty = 2; ty < 8; ty++)
      run(8'(ty), 8'h19, 1, 32'h0, 0, 8'h0, 32'h0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule